// File: doc/BRIEF.md
# Four-Phase Accumulator Machine Controller

A small sequential processor built around a single 16-bit accumulator and one memory that holds both program and data. Every instruction word is 16 bits: a 4-bit operation code in bits 15:12 and a 12-bit memory address in bits 11:0. A phase counter walks each instruction through four one-cycle phases (fetch, decode, prepare, execute). In every phase a decode and control unit drives the strobes of the datapath: the address multiplexer select, the instruction-register load, the program-counter increment and load, the ALU operation select and the accumulator load, shift and clear strobes.

The memory sits outside the block behind one port. The port carries an address, a write strobe and write data, and it returns read data combinationally for the address presented. A write takes effect at the clock edge that ends a cycle in which the strobe is high. The address multiplexer presents the program counter during fetch and the instruction's address field in every other phase. The accumulator, the program counter and the current phase are brought out so that program progress can be observed.

Top module: `accum_seq_cpu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves the program counter at 0, the accumulator at 0 and the phase at fetch (`phase_out` = 0), with `mem_we` low.
- R2: Outside reset, `phase_out` advances by one every cycle in the fixed order fetch (0), decode (1), prepare (2), execute (3), then back to fetch, whatever the operation code.
- R3: During fetch, `mem_addr` equals the program counter, and the word read there becomes the instruction for the next three phases.
- R4: During decode, `mem_addr` equals instruction bits 11:0, and the program counter increments by one modulo 4096 at the end of decode.
- R5: Operation code 3 (add) sets the accumulator to accumulator + M[addr] modulo 2^16 at the end of execute. Operation code 4 (subtract) sets it to accumulator − M[addr] modulo 2^16.
- R6: Operation code 1 (load) sets the accumulator to M[addr] at the end of execute.
- R7: Operation code 2 (store) raises `mem_we` only during execute, with `mem_addr` = addr and `mem_wdata` = accumulator. `mem_we` is low in every other phase and for every other operation code.
- R8: Operation code 5 (jump) loads the program counter with addr at the end of prepare and leaves the accumulator unchanged.
- R9: Operation code 6 jumps as in R8 only when the accumulator is zero. Operation code 7 jumps only when accumulator bit 15 is set. Otherwise the program counter keeps its incremented value.
- R10: Operation code 8 shifts the accumulator right by one bit with a zero entering bit 15. Operation code 9 shifts it left by one bit with a zero entering bit 0. Both act at the end of execute.
- R11: Operation code 10 clears the accumulator at the end of execute.
- R12: Operation codes 0 and 11 to 15 change nothing except the program-counter increment.
- R13: The accumulator changes only at the end of an execute phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address from the address multiplexer |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Data to write (the accumulator) |
| mem_rdata | input | 16 | Data read from `mem_addr`, valid in the same cycle |
| acc_out | output | 16 | Accumulator |
| pc_out | output | 12 | Program counter |
| phase_out | output | 2 | Current phase: 0 fetch, 1 decode, 2 prepare, 3 execute |

## Verification
The bench runs a three-instruction program for each operation and checks the phase, the memory address, the write strobe and the accumulator in every cycle. Changing the timing of any strobe would therefore show up as a value one cycle early or late. The corner cases are chosen to expose specific errors:
- Arithmetic that wraps past 16 bits catches a design that saturates or widens the result.
- A right shift of a word with bit 15 set catches a design that sign-extends.
- Conditional jumps are run both taken and not taken, with a zero accumulator and with a negative one, which catches a test on the wrong flag.
- Undefined operation codes must leave the accumulator alone.
- A jump to address 0xFFF followed by decode checks that the program counter wraps to 0.
- A reset applied in mid-instruction must return the machine to fetch at address 0.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int OPC_W  = DATA_W - ADDR_W;
  localparam int PHASES = 4;
  localparam int PH_W   = $clog2(PHASES);

  typedef enum logic [PH_W-1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_PREP   = 2'd2,
    PH_EXEC   = 2'd3
  } phase_e;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_SUB   = 4'h4,
    OP_JUMP  = 4'h5,
    OP_JZERO = 4'h6,
    OP_JNEG  = 4'h7,
    OP_SHR   = 4'h8,
    OP_SHL   = 4'h9,
    OP_CLEAR = 4'hA
  } opc_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    sel_field;
    logic    ir_ld;
    logic    pc_inc;
    logic    pc_ld;
    alu_op_e alu_op;
    logic    acc_ld;
    logic    acc_shr;
    logic    acc_shl;
    logic    acc_clr;
    logic    mem_wr;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] f_alu(input alu_op_e op,
                                              input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    case (op)
      ALU_ADD: f_alu = a + b;
      ALU_SUB: f_alu = a - b;
      default: f_alu = b;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] f_shift_r(input logic [DATA_W-1:0] a);
    f_shift_r = {1'b0, a[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] f_shift_l(input logic [DATA_W-1:0] a);
    f_shift_l = {a[DATA_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/accum_phase_gen.sv
module accum_phase_gen
  import accum_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase,
  output logic   phase_wrap
);

  logic [PH_W-1:0] cnt_q;

  assign phase_wrap = (cnt_q == PH_W'(PHASES - 1));
  assign phase      = phase_e'(cnt_q);

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (phase_wrap) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  AST_EXEC_TO_FETCH: assert property (@(posedge clk) disable iff (rst) (phase == PH_EXEC) |=> (phase == PH_FETCH)); // R2
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst) (phase == PH_FETCH) |=> (phase == PH_DECODE)); // R2
  AST_DECODE_TO_PREP: assert property (@(posedge clk) disable iff (rst) (phase == PH_DECODE) |=> (phase == PH_PREP)); // R2

endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  phase_e           phase,
  input  logic [OPC_W-1:0] opcode,
  input  logic             acc_zero,
  input  logic             acc_neg,
  output ctrl_t            ctrl_o
);

  opc_e op;
  logic take_jump;

  assign op = opc_e'(opcode);

  always_comb begin
    case (op)
      OP_JUMP:  take_jump = 1'b1;
      OP_JZERO: take_jump = acc_zero;
      OP_JNEG:  take_jump = acc_neg;
      default:  take_jump = 1'b0;
    endcase
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_PASS;
    case (phase)
      PH_FETCH: begin
        ctrl_o.sel_field = 1'b0;
        ctrl_o.ir_ld     = 1'b1;
      end
      PH_DECODE: begin
        ctrl_o.sel_field = 1'b1;
        ctrl_o.pc_inc    = 1'b1;
      end
      PH_PREP: begin
        ctrl_o.sel_field = 1'b1;
        ctrl_o.pc_ld     = take_jump;
        if (op == OP_ADD)      ctrl_o.alu_op = ALU_ADD;
        else if (op == OP_SUB) ctrl_o.alu_op = ALU_SUB;
      end
      default: begin
        ctrl_o.sel_field = 1'b1;
        case (op)
          OP_LOAD:  ctrl_o.acc_ld = 1'b1;
          OP_ADD: begin
            ctrl_o.alu_op = ALU_ADD;
            ctrl_o.acc_ld = 1'b1;
          end
          OP_SUB: begin
            ctrl_o.alu_op = ALU_SUB;
            ctrl_o.acc_ld = 1'b1;
          end
          OP_STORE: ctrl_o.mem_wr  = 1'b1;
          OP_SHR:   ctrl_o.acc_shr = 1'b1;
          OP_SHL:   ctrl_o.acc_shl = 1'b1;
          OP_CLEAR: ctrl_o.acc_clr = 1'b1;
          default:  ;
        endcase
      end
    endcase
  end

  AST_WRITE_IN_EXEC: assert property (@(posedge clk) disable iff (rst) ctrl_o.mem_wr |-> (phase == PH_EXEC)); // R7
  AST_PC_LOAD_IN_PREP: assert property (@(posedge clk) disable iff (rst) ctrl_o.pc_ld |-> (phase == PH_PREP)); // R8
  AST_ACC_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({ctrl_o.acc_ld, ctrl_o.acc_shr, ctrl_o.acc_shl, ctrl_o.acc_clr, ctrl_o.mem_wr})); // R13

endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accum_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] field_addr
);

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] alu_y;

  assign field_addr = ir_q[ADDR_W-1:0];
  assign opcode     = ir_q[DATA_W-1 -: OPC_W];
  assign mem_addr   = ctrl_i.sel_field ? field_addr : pc_q;
  assign mem_wdata  = acc_q;
  assign alu_y      = f_alu(ctrl_i.alu_op, acc_q, mem_rdata);
  assign pc         = pc_q;
  assign acc        = acc_q;

  always_ff @(posedge clk) begin
    if (rst)               pc_q <= '0;
    else if (ctrl_i.pc_ld)  pc_q <= field_addr;
    else if (ctrl_i.pc_inc) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               ir_q <= '0;
    else if (ctrl_i.ir_ld) ir_q <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                 acc_q <= '0;
    else if (ctrl_i.acc_clr) acc_q <= '0;
    else if (ctrl_i.acc_ld)  acc_q <= alu_y;
    else if (ctrl_i.acc_shr) acc_q <= f_shift_r(acc_q);
    else if (ctrl_i.acc_shl) acc_q <= f_shift_l(acc_q);
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) (ctrl_i.pc_inc && !ctrl_i.pc_ld) |=> (pc_q == $past(pc_q) + 1'b1)); // R4
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst) ctrl_i.pc_ld |=> (pc_q == $past(field_addr))); // R8
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst) !ctrl_i.ir_ld |=> $stable(ir_q)); // R3

endmodule

// File: rtl/accum_seq_cpu.sv
module accum_seq_cpu
  import accum_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic [PH_W-1:0]   phase_out
);

  phase_e            phase;
  logic              phase_wrap;
  ctrl_t             ctrl;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] field_addr;
  logic              acc_zero;
  logic              acc_neg;

  accum_phase_gen u_phase (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .phase_wrap (phase_wrap)
  );

  accum_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .opcode   (opcode),
    .acc_zero (acc_zero),
    .acc_neg  (acc_neg),
    .ctrl_o   (ctrl)
  );

  accum_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl_i     (ctrl),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pc         (pc_out),
    .acc        (acc_out),
    .opcode     (opcode),
    .field_addr (field_addr)
  );

  assign acc_zero  = (acc_out == '0);
  assign acc_neg   = acc_out[DATA_W-1];
  assign mem_we    = ctrl.mem_wr;
  assign phase_out = phase;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pc_out == '0 && acc_out == '0 && phase_out == '0 && !mem_we)); // R1
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst) (phase == PH_FETCH) |-> (mem_addr == pc_out)); // R3
  AST_DECODE_ADDR: assert property (@(posedge clk) disable iff (rst) (phase == PH_DECODE) |-> (mem_addr == field_addr)); // R4
  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (rst) (phase != PH_EXEC) |=> $stable(acc_out)); // R13
  AST_WRAP_ONLY_EXEC: assert property (@(posedge clk) disable iff (rst) phase_wrap |-> (phase == PH_EXEC)); // R2

endmodule

// File: tb/tb_accum_seq_cpu.sv
module tb_accum_seq_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [15:0] acc_out;
  logic [11:0] pc_out;
  logic [1:0]  phase_out;

  logic [15:0] mem [256];
  int n_cmp  = 0;
  int n_fail = 0;

  always #2.5ns clk = ~clk;

  accum_seq_cpu dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .acc_out   (acc_out),
    .pc_out    (pc_out),
    .phase_out (phase_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we === 1'b1) mem[mem_addr[7:0]] <= mem_wdata;
  end

  // {opcode, start acc, operand, expected acc, expected pc after two instructions}
  localparam int NV = 15;
  localparam logic [63:0] VEC [NV] = '{
    {4'h1, 16'h1234, 16'hABCD, 16'hABCD, 12'h002},
    {4'h3, 16'h0005, 16'h0003, 16'h0008, 12'h002},
    {4'h3, 16'hFFFF, 16'h0002, 16'h0001, 12'h002},
    {4'h4, 16'h0003, 16'h0005, 16'hFFFE, 12'h002},
    {4'h4, 16'h1000, 16'h0001, 16'h0FFF, 12'h002},
    {4'h8, 16'h8001, 16'hFFFF, 16'h4000, 12'h002},
    {4'h9, 16'h8001, 16'hFFFF, 16'h0002, 12'h002},
    {4'hA, 16'hBEEF, 16'hFFFF, 16'h0000, 12'h002},
    {4'h5, 16'h1111, 16'hFFFF, 16'h1111, 12'h010},
    {4'h6, 16'h0000, 16'hFFFF, 16'h0000, 12'h010},
    {4'h6, 16'h0001, 16'hFFFF, 16'h0001, 12'h002},
    {4'h7, 16'h8000, 16'hFFFF, 16'h8000, 12'h010},
    {4'h7, 16'h7FFF, 16'hFFFF, 16'h7FFF, 12'h002},
    {4'h0, 16'h5A5A, 16'hFFFF, 16'h5A5A, 12'h002},
    {4'hF, 16'h5A5A, 16'hFFFF, 16'h5A5A, 12'h002}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'h1:             op_tag = "R6";
      4'h3, 4'h4:       op_tag = "R5";
      4'h5:             op_tag = "R8";
      4'h6, 4'h7:       op_tag = "R9";
      4'h8, 4'h9:       op_tag = "R10";
      4'hA:             op_tag = "R11";
      default:          op_tag = "R12";
    endcase
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  // Holds reset, lets the caller's program load, releases at a falling edge (cycle 0 = fetch).
  task automatic start_reset();
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_vec(input logic [63:0] v);
    logic [3:0]  op;
    logic [15:0] a, m, ex;
    logic [11:0] epc;
    logic        jmp;
    string       t;
    op  = v[63:60]; a = v[59:44]; m = v[43:28]; ex = v[27:12]; epc = v[11:0];
    jmp = (op == 4'h5) || (op == 4'h6) || (op == 4'h7);
    t   = op_tag(op);
    start_reset();
    clear_mem();
    mem[8'h00] = {4'h1, 12'h080};
    mem[8'h01] = {op, jmp ? 12'h010 : 12'h081};
    mem[8'h02] = {4'h2, 12'h082};
    mem[8'h10] = {4'h2, 12'h082};
    mem[8'h80] = a;
    mem[8'h81] = m;
    release_reset();
    for (int c = 0; c < 12; c++) begin
      if (c > 0) @(negedge clk);
      chk("R2 phase", 32'(phase_out), 32'(c % 4));
      if (c == 0) chk("R3 fetch addr", 32'(mem_addr), 32'h000);
      if (c == 4) chk("R3 fetch addr", 32'(mem_addr), 32'h001);
      if (c == 8) begin
        chk({t, " fetch addr after jump decision"}, 32'(mem_addr), 32'(epc));
        chk({t, " pc"}, 32'(pc_out), 32'(epc));
      end
      if (c == 1) chk("R4 decode addr", 32'(mem_addr), 32'h080);
      if (c == 5) chk("R4 decode addr", 32'(mem_addr), jmp ? 32'h010 : 32'h081);
      if (c == 9) chk("R4 decode addr", 32'(mem_addr), 32'h082);
      chk("R7 write strobe", 32'(mem_we), (c == 11) ? 32'd1 : 32'd0);
      if (c == 11) chk("R7 write data", 32'(mem_wdata), 32'(ex));
      if (c < 4)      chk("R13 acc", 32'(acc_out), 32'h0);
      else if (c < 8) chk("R6 load acc", 32'(acc_out), 32'(a));
      else            chk({t, " acc"}, 32'(acc_out), 32'(ex));
    end
    @(negedge clk);
    chk("R7 stored word", 32'(mem[8'h82]), 32'(ex));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    clear_mem();
    // R1: state right after reset
    start_reset();
    release_reset();
    chk("R1 pc", 32'(pc_out), 32'h0);
    chk("R1 acc", 32'(acc_out), 32'h0);
    chk("R1 phase", 32'(phase_out), 32'h0);
    chk("R1 we", 32'(mem_we), 32'h0);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R1: reset in the middle of an instruction
    start_reset();
    clear_mem();
    mem[8'h00] = {4'h1, 12'h080};
    mem[8'h01] = {4'h3, 12'h080};
    mem[8'h80] = 16'h0077;
    release_reset();
    repeat (6) @(negedge clk);
    chk("R1 mid-run acc nonzero before reset", 32'(acc_out), 32'h0077);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run pc", 32'(pc_out), 32'h0);
    chk("R1 mid-run acc", 32'(acc_out), 32'h0);
    chk("R1 mid-run phase", 32'(phase_out), 32'h0);
    chk("R1 mid-run we", 32'(mem_we), 32'h0);

    // R4: program counter wraps from 0xFFF to 0
    start_reset();
    clear_mem();
    mem[8'h00] = {4'h5, 12'hFFF};
    mem[8'hFF] = 16'h0000;
    release_reset();
    repeat (4) @(negedge clk);
    chk("R4 wrap fetch addr", 32'(mem_addr), 32'hFFF);
    chk("R4 wrap pc", 32'(pc_out), 32'hFFF);
    repeat (2) @(negedge clk);
    chk("R4 wrap pc after decode", 32'(pc_out), 32'h000);
    chk("R12 nop keeps acc", 32'(acc_out), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule